// File: doc/BRIEF.md
# Calorimeter Event Readout Formatter

This block turns one accepted event from a 32-channel calorimeter front-end board into a serial readout frame. The frame is 34 words of 21 bits, sent one word per cycle. The inputs are the event payload and the event identification:

- a 12-bit energy sample and an 8-bit trigger value for each channel;
- a bunch-crossing number and an event number;
- the calibration and test flags;
- two pad-detector bits;
- the fill flags of eight front-end FIFOs and a sequencer flag.

The frame opens with a header word. The 32 channel lines follow, and a trailer closes the frame. The trailer lets the receiver verify every bit column of the lines.

Both sides use a valid/ready handshake. The block captures the whole event in one transfer and then plays the frame out. Downstream backpressure may stall any word for any number of cycles. The formatter offers its input side again only after the trailer has been taken. Channel lines go out in a stride-4 interleaved order. This spreads neighbouring channels across the frame. Every word carries even parity in its top bit.

Top module: `calo_frame_fmt`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `evt_ready` is 1.
- R2: Word 0 of a frame is the header, laid out as follows:
  - bits 7:0: bunch-crossing number;
  - bits 13:8: event number;
  - bits 15:14: `pad_bits`;
  - bit 16: `seq_flag`;
  - bit 18: `evt_test`;
  - bit 19: `evt_calib`.
- R3: Bit 20 of the header makes the 21-bit header word have even parity, so the XOR of all 21 bits is 0.
- R4: Word k of the frame, for k from 1 to 32, carries channel 4·((k−1) mod 8) + floor((k−1)/8). Word 1 is channel 0, word 2 is channel 4, word 9 is channel 1, and word 32 is channel 31.
- R5: A channel line holds the channel's energy sample in bits 11:0 and its trigger value in bits 19:12.
- R6: Bit 20 of a channel line is the XOR of bits 19:0 of that line, so each line has even parity.
- R7: Word 33, the trailer, is the bitwise XOR of the 32 channel lines of the same frame, over all 21 columns.
- R8: The following hold from the transfer that accepts an event until the trailer transfer:
  - exactly 34 words are offered;
  - `evt_ready` is 0 and no further event is taken;
  - after the trailer, `evt_ready` returns to 1 and `out_valid` to 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value.
- R10: Header bit 17 is the AND of the eight `fe_fifo_flag` bits of the accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | An event is presented |
| evt_ready | output | 1 | Formatter can take an event |
| evt_energy | input | 384 | Energy samples; channel c in bits 12c+11:12c |
| evt_trig | input | 256 | Trigger values; channel c in bits 8c+7:8c |
| evt_bxid | input | 8 | Bunch-crossing number |
| evt_evid | input | 6 | Event number, low bits |
| evt_calib | input | 1 | Calibration flag |
| evt_test | input | 1 | Test flag |
| fe_fifo_flag | input | 8 | Fill flags of the eight front-end FIFOs |
| seq_flag | input | 1 | Sequencer status flag |
| pad_bits | input | 2 | Pad-detector bits |
| out_valid | output | 1 | Frame word is offered |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 21 | Frame word |

## Verification
Two things can land in the same cycle:

- Backpressure from `out_ready` can hold the last channel line or the trailer, at the moment the column-parity accumulator would take its final input.
- A new event can be waiting on the input while a frame is still being played out.

The bench holds `evt_valid` high almost continuously, so every frame ends with the next event already pending. It also randomizes `out_ready` for most events, so stalls hit the last line and the trailer. A behavioural queue model is checked on every clock. It compares `out_valid` and `evt_ready` with the model's occupancy. It compares each transferred word with the model's word, and it compares a stalled word with its value in the previous cycle.

// File: rtl/calo_frame_pkg.sv
// Package: shared types for the calorimeter readout formatter.
// Assumes the 21-bit word width is fixed by the header layout.
package calo_frame_pkg;
    localparam int HDR_BX_W = 8;
    localparam int HDR_EV_W = 6;
    localparam int HDR_PAD_W = 2;

    // Kind of word currently offered on the output.
    typedef enum logic [1:0] {
        WK_HEAD  = 2'd0,
        WK_LINE  = 2'd1,
        WK_TRAIL = 2'd2
    } word_kind_e;
endpackage

// File: rtl/calo_line_order.sv
// Module: maps a 0-based line index to the channel it carries.
// The lines go out in a stride-STRIDE interleave: line l carries channel
// STRIDE*(l mod G) + l div G, where G = NCH/STRIDE.
// Assumes NCH is a multiple of STRIDE. Purely combinational.
module calo_line_order #(
    parameter int NCH = 32,
    parameter int STRIDE = 4
) (
    input  logic [$clog2(NCH)-1:0] line_idx,
    output logic [$clog2(NCH)-1:0] ch_idx
);
    localparam int LW = $clog2(NCH);
    localparam int GROUPS = NCH / STRIDE;

    // Index arithmetic for the interleaved order.
    always_comb begin
        ch_idx = LW'((int'(line_idx) % GROUPS) * STRIDE + int'(line_idx) / GROUPS);
    end
endmodule

// File: rtl/calo_line_build.sv
// Module: selects one channel's samples and forms its 21-bit line:
// parity in bit 20, trigger value above the energy sample.
// Assumes the flat inputs pack channel c at offset c*width. Combinational.
module calo_line_build #(
    parameter int NCH = 32,
    parameter int EW = 12,
    parameter int TW = 8
) (
    input  logic [NCH*EW-1:0]      energy_flat,
    input  logic [NCH*TW-1:0]      trig_flat,
    input  logic [$clog2(NCH)-1:0] ch_idx,
    output logic [TW+EW:0]         line_word
);
    logic [EW-1:0] sel_e;
    logic [TW-1:0] sel_t;

    // Channel select and even-parity line assembly.
    always_comb begin
        sel_e     = energy_flat[int'(ch_idx)*EW +: EW];
        sel_t     = trig_flat[int'(ch_idx)*TW +: TW];
        line_word = {^{sel_t, sel_e}, sel_t, sel_e};
    end
endmodule

// File: rtl/calo_col_parity.sv
// Module: running column-wise XOR of the channel lines of one frame.
// A clear takes priority over an accumulate. Synchronous active-low reset.
module calo_col_parity #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc
);
    // Accumulate one line per transferred line word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (en)       acc <= acc ^ din;
    end
endmodule

// File: rtl/calo_frame_fmt.sv
// Module: top of the readout formatter. It captures one event on an input
// handshake, then offers header, NCH interleaved lines and a column-parity
// trailer on a valid/ready output. The offered word is decoded from the
// captured event and the word counter, so a stall needs no extra storage.
// Assumes a synchronous active-low reset and a 21-bit word (TW+EW+1).
module calo_frame_fmt
    import calo_frame_pkg::*;
#(
    parameter int NCH = 32,
    parameter int STRIDE = 4,
    parameter int EW = 12,
    parameter int TW = 8,
    parameter int NFE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    output logic                evt_ready,
    input  logic [NCH*EW-1:0]   evt_energy,
    input  logic [NCH*TW-1:0]   evt_trig,
    input  logic [HDR_BX_W-1:0] evt_bxid,
    input  logic [HDR_EV_W-1:0] evt_evid,
    input  logic                evt_calib,
    input  logic                evt_test,
    input  logic [NFE-1:0]      fe_fifo_flag,
    input  logic                seq_flag,
    input  logic [HDR_PAD_W-1:0] pad_bits,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [TW+EW:0]      out_data
);
    localparam int WORD_W = TW + EW + 1;
    localparam int LW = $clog2(NCH);
    localparam int NWORDS = NCH + 2;
    localparam int CW = $clog2(NWORDS);
    localparam logic [CW-1:0] LAST_IDX = CW'(NWORDS - 1);

    logic               busy;
    logic [CW-1:0]      word_cnt;
    logic [NCH*EW-1:0]  energy_q;
    logic [NCH*TW-1:0]  trig_q;
    logic [WORD_W-2:0]  hdr_body_q;
    logic               accept, fire;
    word_kind_e         kind;
    logic [LW-1:0]      line_idx, ch_idx;
    logic [WORD_W-1:0]  line_word, col_acc;

    assign evt_ready = !busy;
    assign out_valid = busy;
    assign accept    = evt_valid && !busy;
    assign fire      = busy && out_ready;

    // Frame sequencing: word counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            word_cnt <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            word_cnt <= '0;
        end else if (fire) begin
            if (word_cnt == LAST_IDX) begin
                busy     <= 1'b0;
                word_cnt <= '0;
            end else begin
                word_cnt <= word_cnt + 1'b1;
            end
        end
    end

    // Event capture: payload and header body, taken on the input transfer.
    always_ff @(posedge clk) begin
        if (accept) begin
            energy_q   <= evt_energy;
            trig_q     <= evt_trig;
            hdr_body_q <= {evt_calib, evt_test, &fe_fifo_flag, seq_flag,
                           pad_bits, evt_evid, evt_bxid};
        end
    end

    // Word kind decode from the counter.
    always_comb begin
        if (word_cnt == '0)            kind = WK_HEAD;
        else if (word_cnt == LAST_IDX) kind = WK_TRAIL;
        else                           kind = WK_LINE;
    end

    assign line_idx = LW'(word_cnt - 1'b1);

    calo_line_order #(.NCH(NCH), .STRIDE(STRIDE)) u_order (
        .line_idx (line_idx),
        .ch_idx   (ch_idx)
    );

    calo_line_build #(.NCH(NCH), .EW(EW), .TW(TW)) u_build (
        .energy_flat (energy_q),
        .trig_flat   (trig_q),
        .ch_idx      (ch_idx),
        .line_word   (line_word)
    );

    calo_col_parity #(.W(WORD_W)) u_colpar (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (fire && kind == WK_LINE),
        .din   (line_word),
        .acc   (col_acc)
    );

    // Output word multiplexer.
    always_comb begin
        unique case (kind)
            WK_HEAD:  out_data = {^hdr_body_q, hdr_body_q};
            WK_LINE:  out_data = line_word;
            default:  out_data = col_acc;
        endcase
    end
endmodule

// File: rtl/calo_frame_fmt_chk.sv
// Module: protocol and parity checker for the formatter, bound to its top.
// It tracks the word position and column XOR from the output port alone.
module calo_frame_fmt_chk #(
    parameter int NCH = 32,
    parameter int WORD_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              evt_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data
);
    localparam int CW = $clog2(NCH + 2);
    localparam logic [CW-1:0] TRAIL_IDX = CW'(NCH + 1);

    logic [CW-1:0]     pos;
    logic [WORD_W-1:0] xacc;

    // Observer: word position in the frame and XOR of observed lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            xacc <= '0;
        end else if (out_valid && out_ready) begin
            if (pos == '0)             xacc <= '0;
            else if (pos != TRAIL_IDX) xacc <= xacc ^ out_data;
            pos <= (pos == TRAIL_IDX) ? '0 : pos + 1'b1;
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !evt_ready);

    // R8
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_ready |=> out_valid && pos == '0);

    // R3 R6
    word_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (^out_data) == 1'b0);

    // R7
    trailer_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && pos == TRAIL_IDX |-> out_data == xacc);
endmodule

bind calo_frame_fmt calo_frame_fmt_chk #(.NCH(NCH), .WORD_W(TW + EW + 1)) u_fmt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/calo_frame_fmt_bench.sv
// Bench: behavioural queue model, compared on every clock.
module calo_frame_fmt_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int EW = 12;
    localparam int TW = 8;
    localparam int WW = 21;
    localparam int NEV = 60;
    localparam int LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0;
    logic evt_ready;
    logic [NCH*EW-1:0] evt_energy = '0;
    logic [NCH*TW-1:0] evt_trig = '0;
    logic [7:0] evt_bxid = '0;
    logic [5:0] evt_evid = '0;
    logic evt_calib = 1'b0, evt_test = 1'b0, seq_flag = 1'b0;
    logic [7:0] fe_fifo_flag = '0;
    logic [1:0] pad_bits = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [WW-1:0] out_data;

    calo_frame_fmt u_calo_frame_fmt (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_energy(evt_energy), .evt_trig(evt_trig), .evt_bxid(evt_bxid),
        .evt_evid(evt_evid), .evt_calib(evt_calib), .evt_test(evt_test),
        .fe_fifo_flag(fe_fifo_flag), .seq_flag(seq_flag), .pad_bits(pad_bits),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [WW-1:0] exp_q[$];
    bit            fe_and_q[$];
    int            kind_q[$];
    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // Fill the input ports with an event of the given pattern.
    task automatic load_event(int n);
        int pat = (n < 3) ? n : 3;
        for (int c = 0; c < NCH; c++) begin
            case (pat)
                0: begin evt_energy[c*EW +: EW] = '0; evt_trig[c*TW +: TW] = '0; end
                1: begin evt_energy[c*EW +: EW] = '1; evt_trig[c*TW +: TW] = '1; end
                2: begin evt_energy[c*EW +: EW] = EW'(c); evt_trig[c*TW +: TW] = TW'(8'hA0 + c); end
                default: begin
                    evt_energy[c*EW +: EW] = EW'($urandom);
                    evt_trig[c*TW +: TW] = TW'($urandom);
                end
            endcase
        end
        evt_bxid = 8'($urandom);
        evt_evid = 6'($urandom);
        evt_calib = 1'($urandom);
        evt_test = 1'($urandom);
        seq_flag = 1'($urandom);
        pad_bits = 2'($urandom);
        fe_fifo_flag = (n % 3 == 1) ? 8'hFF : 8'($urandom);
        if (n % 5 == 2) fe_fifo_flag = 8'hFF ^ (8'h1 << (n % 8));
    endtask

    // Reference model: expected words of the frame for the presented event.
    task automatic push_frame();
        logic [WW-1:0] trl = '0;
        logic [19:0] body;
        int ord[$];
        body = {evt_calib, evt_test, &fe_fifo_flag, seq_flag, pad_bits, evt_evid, evt_bxid};
        exp_q.push_back({^body, body}); kind_q.push_back(0);
        fe_and_q.push_back(&fe_fifo_flag);
        for (int g = 0; g < 4; g++)
            for (int k = 0; k < 8; k++) ord.push_back(4*k + g);
        for (int l = 0; l < NCH; l++) begin
            logic [19:0] d = {evt_trig[ord[l]*TW +: TW], evt_energy[ord[l]*EW +: EW]};
            logic [WW-1:0] w = {^d, d};
            trl ^= w;
            exp_q.push_back(w); kind_q.push_back(1); fe_and_q.push_back(1'b0);
        end
        exp_q.push_back(trl); kind_q.push_back(2); fe_and_q.push_back(1'b0);
    endtask

    initial begin
        int sent = 0;
        int cyc = 0;
        bit pend = 0;
        bit stalled = 0;
        logic [WW-1:0] prev = '0;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
            chk(evt_ready == 1'b1, "R1 evt_ready", evt_ready, 1);
        end
        rst_n = 1'b1;
        while (!(sent == NEV && !pend && exp_q.size() == 0)) begin
            @(negedge clk);
            cyc++;
            if (cyc > LIMIT) begin
                n_fail++;
                $display("FAIL watchdog expired after %0d cycles", cyc);
                break;
            end
            if (!pend) begin
                evt_valid = 1'b0;
                if (sent < NEV && ($urandom % 5) != 0) begin
                    load_event(sent);
                    evt_valid = 1'b1;
                    pend = 1;
                end
            end
            out_ready = (sent < 8) ? 1'b1 : (($urandom % 3) != 0);
            #1;
            // R8: occupancy agrees with the model
            chk(out_valid == (exp_q.size() != 0), "R8 out_valid", out_valid, exp_q.size() != 0);
            chk(evt_ready == (exp_q.size() == 0), "R8 evt_ready", evt_ready, exp_q.size() == 0);
            // R9: stalled word held
            if (stalled) chk(out_data == prev, "R9 stall", out_data, prev);
            if (out_valid && out_ready && exp_q.size() != 0) begin
                case (kind_q[0])
                    0: begin
                        chk(out_data == exp_q[0], "R2 R3 header", out_data, exp_q[0]);
                        chk(out_data[17] == fe_and_q[0], "R10 fifo and", out_data[17], fe_and_q[0]);
                    end
                    1: chk(out_data == exp_q[0], "R4 R5 R6 line", out_data, exp_q[0]);
                    default: chk(out_data == exp_q[0], "R7 trailer", out_data, exp_q[0]);
                endcase
                void'(exp_q.pop_front()); void'(kind_q.pop_front()); void'(fe_and_q.pop_front());
            end
            if (evt_valid && evt_ready) begin
                push_frame();
                pend = 0;
                sent++;
            end
            stalled = out_valid && !out_ready;
            prev = out_data;
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule